// File: doc/BRIEF.md
# Paired-Output External Interrupt Detector

This block is the front end for eight external interrupt pins. Every pin is first brought into the core clock domain, and then tested against a detection condition that is chosen separately for each pin: low level, high level, rising edge or falling edge. When a pin meets its condition, a pending flag for that channel is set. The flag stays set until software clears it.

Three registers sit behind a simple single-cycle register bus: a channel enable mask, the pending flags, and a mode word that holds two bits per channel. Channels are combined in neighbouring pairs onto four interrupt request lines. A line is high while either channel of its pair has a pending flag that is also enabled. Requests leave in order: pair 0/1 on line 0, up to pair 6/7 on line 3. An interrupt controller outside the block consumes them.

Flags record detections even for disabled channels, so software can poll them. In a level mode the flag is re-armed on every cycle that the level persists.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, the enable register, the flag register and the mode register all read 0, and all four request lines are low.
- R2: Register addresses are as follows. Address 0 is the enable mask in bits 7:0. Address 1 is the flag register in bits 7:0. Address 2 is the mode word, where channel c uses bits 2c+1:2c. Address 3 reads as 0, and unused upper bits read as 0. A write stores its data at the clock edge where bus_wr is high, and reads are combinational.
- R3: Mode 10 is rising edge. A rise on a pin, applied between clock edges, sets that channel's flag at the third rising clock edge after the change. A fall on the pin sets nothing.
- R4: Mode 11 is falling edge. A fall on a pin sets that channel's flag at the third rising clock edge after the change.
- R5: Mode 01 is high level. The flag is set on every clock edge while the synchronised pin is high, so writing 0 to clear it has no lasting effect until the pin has gone low.
- R6: Mode 00 is low level. The flag is set on every clock edge while the synchronised pin is low. Once the pin is high, a clear sticks.
- R7: A flag is set whether or not its channel is enabled. A request line stays low when neither channel of its pair is enabled.
- R8: Writing 0 to a bit at address 1 clears that flag. Writing 1 leaves the flag unchanged.
- R9: When a detection and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R10: Request line j equals (flag[2j] AND enable[2j]) OR (flag[2j+1] AND enable[2j+1]). It follows a register change combinationally, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational |
| irq_o | output | 4 | Paired interrupt request lines |

## Verification
A pin change applied between clock edges reaches the flag at the third rising edge. Two edges go to the synchroniser. The third edge is the one where the detection is registered. Register writes take effect at the first edge, and the request lines follow the registers with no extra cycle.

The directed checks therefore read results at the falling edge after exactly the number of rising edges each result needs. Each edge case is also read one edge early, where it must still be clear. The set-against-clear case is timed so that the bus write lands on the same edge as the detection. A behavioural model, built on a history queue of sampled pin values, predicts the request lines and the read data. It is compared with the design a quarter period after every rising edge.

// File: rtl/eirq_pkg.sv
// Shared definitions for the external interrupt detector: detection
// mode encoding and register addresses. Assumes a 2-bit address space.
package eirq_pkg;
    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_e;

    localparam logic [1:0] ADDR_EN   = 2'd0;
    localparam logic [1:0] ADDR_FLAG = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
endpackage

// File: rtl/eirq_sync.sv
// Two-stage synchroniser for a vector of independent asynchronous pins.
// Assumes each bit is sampled on its own; no cross-bit coherence is implied.
module eirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Shift the pins through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/eirq_detect.sv
// Per-channel condition detector. Compares each synchronised pin with its
// value one cycle earlier and applies that channel's 2-bit mode.
// Assumes sync_i is already in the clock domain.
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int MW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sync_i,
    input  logic [MW-1:0]  mode_i,
    output logic [NCH-1:0] hit_o
);
    logic [NCH-1:0] prev_q;

    // Keep last cycle's synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        det_mode_e mode_c;
        assign mode_c = det_mode_e'(mode_i[2*c +: 2]);

        // Evaluate this channel's selected condition.
        always_comb begin
            unique case (mode_c)
                DET_LOW:  hit_o[c] = ~sync_i[c];
                DET_HIGH: hit_o[c] =  sync_i[c];
                DET_RISE: hit_o[c] =  sync_i[c] & ~prev_q[c];
                DET_FALL: hit_o[c] = ~sync_i[c] &  prev_q[c];
                default:  hit_o[c] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eirq_regs.sv
// Register file: enable mask, pending flags and mode word. Flags set on a
// detection, clear on a written 0; a detection wins over a same-cycle clear.
// Assumes single-cycle writes and combinational reads.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int MW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [1:0]     addr_i,
    input  logic [MW-1:0]  wdata_i,
    output logic [MW-1:0]  rdata_o,
    input  logic [NCH-1:0] hit_i,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] flag_o,
    output logic [MW-1:0]  mode_o,
    output logic [NCH-1:0] clr_o
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] flag_q;
    logic [MW-1:0]  mode_q;

    // Form the clear mask from zeros written to the flag address.
    always_comb begin
        clr_o = '0;
        if (wr_i && addr_i == ADDR_FLAG) clr_o = ~wdata_i[NCH-1:0];
    end

    // Update the enable and mode registers from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_EN)   en_q   <= wdata_i[NCH-1:0];
            if (addr_i == ADDR_MODE) mode_q <= wdata_i;
        end
    end

    // Update the pending flags: clear first, then let detections win.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_o) | hit_i;
    end

    // Select the read data for the addressed register.
    always_comb begin
        unique case (addr_i)
            ADDR_EN:   rdata_o = MW'(en_q);
            ADDR_FLAG: rdata_o = MW'(flag_q);
            ADDR_MODE: rdata_o = mode_q;
            default:   rdata_o = '0;
        endcase
    end

    assign en_o   = en_q;
    assign flag_o = flag_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/eirq_merge.sv
// Merges enabled pending flags in groups of GRP adjacent channels onto one
// request line per group. Assumes NCH is a multiple of GRP.
module eirq_merge #(
    parameter int NCH = 8,
    parameter int GRP = 2,
    localparam int NOUT = NCH / GRP
) (
    input  logic [NCH-1:0]  flag_i,
    input  logic [NCH-1:0]  en_i,
    output logic [NOUT-1:0] irq_o
);
    logic [NCH-1:0] live;
    assign live = flag_i & en_i;

    for (genvar j = 0; j < NOUT; j++) begin : g_out
        assign irq_o[j] = |live[j*GRP +: GRP];
    end
endmodule

// File: rtl/ext_irq_front.sv
// Top of the external interrupt detector: synchroniser, detector, register
// file and pair merge. Assumes pins are asynchronous and the bus is
// synchronous to clk.
module ext_irq_front #(
    parameter int NCH = 8,
    parameter int GRP = 2,
    localparam int NOUT = NCH / GRP,
    localparam int MW = 2 * NCH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  pin_i,
    input  logic            bus_wr,
    input  logic [1:0]      bus_addr,
    input  logic [MW-1:0]   bus_wdata,
    output logic [MW-1:0]   bus_rdata,
    output logic [NOUT-1:0] irq_o
);
    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] hit_vec;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] clr_vec;
    logic [MW-1:0]  mode_q;

    eirq_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
    );

    eirq_detect #(.NCH(NCH)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .mode_i(mode_q),
        .hit_o(hit_vec)
    );

    eirq_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .hit_i(hit_vec),
        .en_o(en_q), .flag_o(flag_q), .mode_o(mode_q), .clr_o(clr_vec)
    );

    eirq_merge #(.NCH(NCH), .GRP(GRP)) u_merge (
        .flag_i(flag_q), .en_i(en_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/eirq_chk.sv
// Checker for the external interrupt detector, bound to the top module.
// Watches flag, enable, detection and clear signals against the request lines.
module eirq_chk #(
    parameter int NCH = 8,
    parameter int GRP = 2,
    localparam int NOUT = NCH / GRP
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NOUT-1:0] irq_o,
    input logic [NCH-1:0]  flag,
    input logic [NCH-1:0]  en,
    input logic [NCH-1:0]  hit,
    input logic [NCH-1:0]  clr
);
    // R7
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (irq_o == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_flag
        // R8
        flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(hit[i]));
        // R8
        flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[i]) |-> $past(clr[i]));
        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(hit[i])) |-> flag[i]);
    end

    for (genvar j = 0; j < NOUT; j++) begin : g_out
        // R10
        irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[j] |-> ((flag[2*j] && en[2*j]) || (flag[2*j+1] && en[2*j+1])));
    end
endmodule

bind ext_irq_front eirq_chk #(.NCH(NCH), .GRP(GRP)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .flag(flag_q), .en(en_q),
    .hit(hit_vec), .clr(clr_vec)
);

// File: tb/tb_ext_irq_front.sv
module tb_ext_irq_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq_o;

    int checks = 0;
    int failures = 0;

    ext_irq_front dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: pin history queue and model registers.
    logic [7:0]  m_en, m_flag;
    logic [15:0] m_mode;
    logic [7:0]  hist[$];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_flag = '0; m_mode = '0;
            hist = {8'h00, 8'h00, 8'h00};
        end else begin
            logic [7:0] cur, prv, setv, clrv;
            logic [3:0] exp_irq;
            logic [15:0] exp_rd;
            cur = hist[hist.size()-2];
            prv = hist[hist.size()-3];
            setv = '0;
            for (int c = 0; c < 8; c++) begin
                case ({m_mode[2*c+1], m_mode[2*c]})
                    2'b00: setv[c] = !cur[c];
                    2'b01: setv[c] = cur[c];
                    2'b10: setv[c] = cur[c] && !prv[c];
                    default: setv[c] = !cur[c] && prv[c];
                endcase
            end
            clrv = (bus_wr && bus_addr == 2'd1) ? ~bus_wdata[7:0] : 8'h00;
            m_flag = (m_flag & ~clrv) | setv;
            if (bus_wr && bus_addr == 2'd0) m_en = bus_wdata[7:0];
            if (bus_wr && bus_addr == 2'd2) m_mode = bus_wdata;
            hist.push_back(pin_i);
            if (hist.size() > 4) void'(hist.pop_front());
            #(CLK_PERIOD/4);
            for (int j = 0; j < 4; j++)
                exp_irq[j] = (m_flag[2*j] & m_en[2*j]) | (m_flag[2*j+1] & m_en[2*j+1]);
            case (bus_addr)
                2'd0: exp_rd = {8'h00, m_en};
                2'd1: exp_rd = {8'h00, m_flag};
                2'd2: exp_rd = m_mode;
                default: exp_rd = 16'h0000;
            endcase
            chk("R10 model irq", {12'h000, irq_o}, {12'h000, exp_irq});
            chk("R2 model rdata", bus_rdata, exp_rd);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] d;
        tick(4);
        rst_n = 1'b1;
        // R1: reset state before any enabled edge
        rd(2'd0, d); chk("R1 enable", d, 16'h0000);
        rd(2'd1, d); chk("R1 flags", d, 16'h0000);
        rd(2'd2, d); chk("R1 mode", d, 16'h0000);
        chk("R1 irq", {12'h000, irq_o}, 16'h0000);

        // R6: low level with pins low sets all flags
        tick(3);
        rd(2'd1, d); chk("R6 low level set", d, 16'h00FF);
        pin_i = 8'hFF;
        tick(2);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R6 clear after level left", d, 16'h0000);
        // R8: writing ones has no effect
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); chk("R8 ones no effect", d, 16'h0000);

        // R2: register map readback
        wr(2'd0, 16'h00A5);
        rd(2'd0, d); chk("R2 enable readback", d, 16'h00A5);
        wr(2'd2, 16'h1234);
        rd(2'd2, d); chk("R2 mode readback", d, 16'h1234);
        rd(2'd3, d); chk("R2 unused address", d, 16'h0000);

        // R3: all channels rising edge
        wr(2'd2, 16'hAAAA);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R3 cleared", d, 16'h0000);
        pin_i[0] = 1'b0;
        tick(4);
        rd(2'd1, d); chk("R3 fall ignored", d, 16'h0000);
        pin_i[0] = 1'b1;
        tick(2);
        rd(2'd1, d); chk("R3 not yet after two edges", d, 16'h0000);
        tick(1);
        rd(2'd1, d); chk("R3 set at third edge", d, 16'h0001);
        // R7: flag set while disabled keeps irq low
        chk("R7 disabled irq", {12'h000, irq_o}, 16'h0000);
        wr(2'd0, 16'h0002);
        chk("R10 partner only enabled", {12'h000, irq_o}, 16'h0000);
        wr(2'd0, 16'h0001);
        chk("R10 pair0 line", {12'h000, irq_o}, 16'h0001);

        // R4: channel 2 falling edge
        wr(2'd2, 16'hAABA);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0004);
        pin_i[2] = 1'b0;
        tick(2);
        rd(2'd1, d); chk("R4 not yet", d, 16'h0000);
        tick(1);
        rd(2'd1, d); chk("R4 fall sets", d, 16'h0004);
        chk("R10 pair1 line", {12'h000, irq_o}, 16'h0002);

        // R5: channel 4 high level persists through a clear
        wr(2'd2, 16'hA9BA);
        tick(1);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R5 clear blocked while high", d & 16'h0010, 16'h0010);
        pin_i[4] = 1'b0;
        tick(3);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R5 clear after low", d, 16'h0000);

        // R9: detection and clear on the same edge (channel 6 rising)
        pin_i[6] = 1'b0;
        tick(3);
        wr(2'd1, 16'h0000);
        pin_i[6] = 1'b1;
        tick(2);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R9 set wins", d & 16'h0040, 16'h0040);

        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule